// File: doc/BRIEF.md
# Pipelined Convolutional BP Decoder Scheduler

This block is the index and schedule controller for a windowed, pipelined belief-propagation decoder of a convolutional low-density parity-check code. The code is built by unwrapping a quasi-cyclic base matrix. Its period is `MS+1` frames, where `MS` is the syndrome-former memory. The decoder has `NPROC` processors, one per iteration. Together they share a circular channel-message buffer of `W = NPROC*(MS+1)` frame slots. The buffer never moves. A frame advances from one processor to the next because the slot indices are relabelled on every frame tick.

Each `tick` marks one frame time `t`, counted from zero since reset. One cycle after the tick, the block presents the following, framed by an `out_vld` pulse:
- the slot that the incoming frame is written to;
- for each processor, the check layer it updates and the slot of the variable frame it updates;
- an enable for each of those two updates;
- the slot of the oldest resident frame, together with a hard-decision strobe that releases it.

During start-up, processors whose work would fall on frames that have not yet arrived are held idle. The whole schedule is built from wrapping counters and constant offsets, so it needs no divider.

Top module: `conv_bp_sched`

## Requirements
- R1: After reset, `out_vld`, `hd_vld`, every bit of `chk_en` and every bit of `var_en` are low. The first tick after reset is frame time 0.
- R2: `out_vld` is high for exactly the one cycle after each cycle in which `tick` is high, and is low in all other cycles. All other outputs are read while `out_vld` is high.
- R3: For frame time `t`, `wr_slot` equals `t mod W`.
- R4: Processor `p` (p = 0 to NPROC-1) occupies bits `[p*LW +: LW]` of `chk_layer`, where `LW = clog2(W)`. Its check layer is `(t mod (MS+1)) + p*(MS+1)`.
- R5: `chk_en[p]` is high exactly when `t >= p*(MS+1)`. This gives partial check updates while the pipeline fills.
- R6: `var_en[p]` is high exactly when `t >= p*(MS+1)+MS`, that is, when the target frame `t-MS-p*(MS+1)` is not negative.
- R7: Processor `p` occupies bits `[p*LW +: LW]` of `var_slot`. Its variable-frame slot is `(t-MS-p*(MS+1)) mod W`, taken as a non-negative value.
- R8: `hd_vld` is high exactly when `t >= W`. `hd_slot` then equals `(t-W) mod W`, the slot of the oldest frame, which the incoming frame reuses.
- R9: A reset in mid-run clears the schedule, so the next tick is frame time 0 again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| tick | input | 1 | One frame time elapses |
| out_vld | output | 1 | Schedule outputs valid for the latest tick |
| wr_slot | output | LW | Slot written by the incoming frame |
| chk_layer | output | NPROC*LW | Check layer for each processor |
| chk_en | output | NPROC | Check update enable for each processor |
| var_slot | output | NPROC*LW | Variable-frame slot for each processor |
| var_en | output | NPROC | Variable update enable for each processor |
| hd_vld | output | 1 | Hard decision on the oldest frame |
| hd_slot | output | LW | Slot of the frame released by hard decision |

## Verification
Every result of a tick is due exactly one clock edge after the tick was sampled, so `out_vld` and all index buses appear in the cycle that follows. The driver pushes the frame time of each tick into a queue. The monitor pops that entry at the falling edge of the cycle in which `out_vld` is high, and compares every field against values computed from the frame time. In the gap cycles between ticks, the driver checks that `out_vld` stays low. Ticks are sent both back to back and with gaps, long enough to pass the start-up phase and several wraps of the buffer.

// File: rtl/conv_bp_sched.sv
module conv_bp_sched #(
  parameter int MS    = 3,
  parameter int NPROC = 4
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  tick,
  output logic                  out_vld,
  output logic [$clog2(NPROC*(MS+1))-1:0]       wr_slot,
  output logic [NPROC*$clog2(NPROC*(MS+1))-1:0] chk_layer,
  output logic [NPROC-1:0]      chk_en,
  output logic [NPROC*$clog2(NPROC*(MS+1))-1:0] var_slot,
  output logic [NPROC-1:0]      var_en,
  output logic                  hd_vld,
  output logic [$clog2(NPROC*(MS+1))-1:0]       hd_slot
);
  localparam int P  = MS + 1;
  localparam int W  = NPROC * P;
  localparam int LW = $clog2(W);
  localparam int TW = $clog2(W + 1);
  localparam int KW = (P > 1) ? $clog2(P) : 1;

  logic [TW-1:0] nxt_t, cur_t;
  logic [LW-1:0] nxt_slot, cur_slot;
  logic [KW-1:0] nxt_kap, cur_kap;
  logic          vld_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      nxt_t <= '0; cur_t <= '0;
      nxt_slot <= '0; cur_slot <= '0;
      nxt_kap <= '0; cur_kap <= '0;
      vld_q <= 1'b0;
    end else begin
      vld_q <= tick;
      if (tick) begin
        cur_t    <= nxt_t;
        cur_slot <= nxt_slot;
        cur_kap  <= nxt_kap;
        nxt_slot <= (nxt_slot == LW'(W - 1)) ? '0 : nxt_slot + 1'b1;
        nxt_kap  <= (nxt_kap == KW'(P - 1)) ? '0 : nxt_kap + 1'b1;
        if (nxt_t != TW'(W)) nxt_t <= nxt_t + 1'b1;
      end
    end
  end

  assign out_vld = vld_q;
  assign wr_slot = cur_slot;
  assign hd_vld  = vld_q && (cur_t == TW'(W));
  assign hd_slot = cur_slot;

  for (genvar p = 0; p < NPROC; p++) begin : g_proc
    localparam int BASE = p * P;
    localparam int OFF  = MS + p * P;
    logic [LW:0] sum;
    assign sum = {1'b0, cur_slot} + (LW+1)'(W - OFF);
    assign var_slot[p*LW +: LW]  = (sum >= (LW+1)'(W)) ? LW'(sum - (LW+1)'(W)) : LW'(sum);
    assign chk_layer[p*LW +: LW] = LW'(cur_kap) + LW'(BASE);
    assign chk_en[p] = vld_q && (cur_t >= TW'(BASE));
    assign var_en[p] = vld_q && (cur_t >= TW'(BASE + MS));
  end

  // R2
  vld_after_tick_chk: assert property (@(posedge clk) disable iff (rst)
    out_vld |-> $past(tick));
  // R8
  hd_needs_vld_chk: assert property (@(posedge clk) disable iff (rst)
    hd_vld |-> out_vld);
  // R8
  hd_stays_chk: assert property (@(posedge clk) disable iff (rst)
    (out_vld && $past(hd_vld)) |-> hd_vld);
  // R3
  slot_step_chk: assert property (@(posedge clk) disable iff (rst)
    (out_vld && $past(out_vld) && $past(wr_slot) != LW'(W - 1)) |-> wr_slot == $past(wr_slot) + 1'b1);
  // R6
  var_implies_chk_chk: assert property (@(posedge clk) disable iff (rst)
    (var_en & ~chk_en) == '0);
  // R4
  first_layer_chk: assert property (@(posedge clk) disable iff (rst)
    out_vld |-> chk_layer[LW-1:0] <= LW'(MS));
endmodule

// File: tb/conv_bp_sched_bench.sv
module conv_bp_sched_bench;
  localparam int CLK_PERIOD = 10;
  localparam int MS = 3;
  localparam int NPROC = 4;
  localparam int P = MS + 1;
  localparam int W = NPROC * P;
  localparam int LW = $clog2(W);

  logic clk = 0, rst = 1, tick = 0;
  logic out_vld, hd_vld;
  logic [LW-1:0] wr_slot, hd_slot;
  logic [NPROC*LW-1:0] chk_layer, var_slot;
  logic [NPROC-1:0] chk_en, var_en;

  int n_chk = 0, n_fail = 0;
  int q[$];
  int t_model = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  conv_bp_sched #(.MS(MS), .NPROC(NPROC)) u_conv_bp_sched (
    .clk(clk), .rst(rst), .tick(tick), .out_vld(out_vld), .wr_slot(wr_slot),
    .chk_layer(chk_layer), .chk_en(chk_en), .var_slot(var_slot), .var_en(var_en),
    .hd_vld(hd_vld), .hd_slot(hd_slot));

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic send(input int gap);
    @(negedge clk);
    tick = 1;
    q.push_back(t_model);
    t_model++;
    if (gap > 0) begin
      @(negedge clk);
      tick = 0;
      for (int g = 1; g < gap; g++) begin
        @(negedge clk);
        check(out_vld == 0, "R2 idle", int'(out_vld), 0);
      end
    end
  endtask

  always @(negedge clk) begin
    if (!rst && out_vld) begin
      if (q.size() == 0) check(0, "R2 unexpected", 1, 0);
      else begin
        int t;
        t = q.pop_front();
        check(wr_slot == LW'(t % W), "R3 wr_slot", int'(wr_slot), t % W);
        for (int p = 0; p < NPROC; p++) begin
          int el, es;
          el = (t % P) + p * P;
          es = (((t - MS - p * P) % W) + W) % W;
          check(chk_layer[p*LW +: LW] == LW'(el), "R4 chk_layer", int'(chk_layer[p*LW +: LW]), el);
          check(chk_en[p] == (t >= p * P), "R5 chk_en", int'(chk_en[p]), int'(t >= p * P));
          check(var_en[p] == (t >= p * P + MS), "R6 var_en", int'(var_en[p]), int'(t >= p * P + MS));
          check(var_slot[p*LW +: LW] == LW'(es), "R7 var_slot", int'(var_slot[p*LW +: LW]), es);
        end
        check(hd_vld == (t >= W), "R8 hd_vld", int'(hd_vld), int'(t >= W));
        if (t >= W) check(hd_slot == LW'(t % W), "R8 hd_slot", int'(hd_slot), t % W);
      end
    end
  end

  initial begin
    int cyc = 0;
    while (!done) begin
      @(posedge clk);
      cyc++;
      if (cyc > 100000) begin
        check(0, "watchdog", cyc, 100000);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R1
    check(out_vld == 0 && hd_vld == 0, "R1 strobes", int'(out_vld) + int'(hd_vld), 0);
    check(chk_en == 0 && var_en == 0, "R1 enables", int'(chk_en) + int'(var_en), 0);
    for (int i = 0; i < 45; i++) send(i % 3);
    @(negedge clk); tick = 0;
    repeat (3) @(negedge clk);
    // R9 mid-run reset
    rst = 1;
    repeat (2) @(negedge clk);
    rst = 0;
    q.delete();
    t_model = 0;
    @(negedge clk);
    check(out_vld == 0 && hd_vld == 0, "R9 after reset", int'(out_vld) + int'(hd_vld), 0);
    for (int i = 0; i < 2 * W + 3; i++) send((i % 4 == 0) ? 2 : 0);
    @(negedge clk); tick = 0;
    repeat (3) @(negedge clk);
    check(q.size() == 0, "R2 all results seen", q.size(), 0);
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule